// File: doc/BRIEF.md
# Program/Erase Busy Status Reporter

This block times a self-running program or erase operation. While that operation is busy, it also replaces selected bits of the read data with status, so that a host can poll for completion. A command decoder issues a single-cycle start strobe. With the strobe it gives the operation kind and the word that was last loaded. From that cycle the block counts a fixed number of clock cycles, chosen by parameter for each operation kind, and then returns to normal reads by itself. The host takes no part in ending the operation.

During the busy window, two bits of every byte lane carry status in place of array contents. The top bit of each lane is a polling bit. For a program it reads as the inverse of the word that was loaded, and for an erase it reads as zero. The bit just below it is a toggle bit that changes value after every read strobe. All other bits pass the array data through. When the timer expires, the block raises a one-cycle completion pulse so that the array update can be committed. From then on, reads return the array word unchanged.

Top module: `busy_status_reporter`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `rd_data_o` equals `array_data_i`.
- R2: A start strobe seen while idle raises `busy_o` from the next cycle. `busy_o` then stays high for exactly PROG_CYCLES cycles when `op_erase_i` was 0 (program), or ERASE_CYCLES cycles when it was 1 (erase).
- R3: `busy_o` clears by itself when the count expires. `done_o` is high for exactly the one cycle that follows the last busy cycle.
- R4: A start strobe while busy is ignored. The operation kind, the latched word and the remaining duration keep the values of the operation already running.
- R5: While a program is busy, bit 7 of each byte lane (bits 7 and 15) reads as the complement of the same bit of the latched word.
- R6: While an erase is busy, bits 7 and 15 read as 0.
- R7: While busy, bits 6 and 14 read the same value. That value is 0 on the first read of an operation and inverts after each busy cycle that has `rd_i` high. Cycles without `rd_i` leave it unchanged.
- R8: While busy, all bits except 15, 14, 7 and 6 equal `array_data_i`.
- R9: While not busy, `rd_data_o` equals `array_data_i` whatever `rd_i` does, and read strobes start nothing.
- R10: Once an erase has completed, reads return the array word, so an erased array reads its all-ones contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that starts an operation |
| op_erase_i | input | 1 | Operation kind with the strobe: 0 program, 1 erase |
| wdata_i | input | DATA_W | Last loaded word, captured with the strobe |
| rd_i | input | 1 | Host read strobe, advances the toggle bit while busy |
| array_data_i | input | DATA_W | True array read data |
| rd_data_o | output | DATA_W | Data returned to the host |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse after the operation ends |

## Verification
The hardest situation to reach is a start strobe that arrives in the middle of a busy window. That strobe carries the opposite operation kind and the inverted word. The stimulus injects it on the second busy cycle of selected runs. It then checks that both the polling polarity and the busy length still follow the first operation. Toggle behaviour depends on the history of read strobes, so the read pattern differs from run to run. Some runs also end on an odd number of reads, which shows that the next operation starts its toggle bit at 0 again. The program sweep covers all 16 combinations of the four status bit positions in the loaded word.

// File: rtl/bsr_pkg.sv
// Package for the busy status reporter.
// Holds the operation encoding, the lane layout and a helper that builds
// the mask of status bit positions. Assumes the data width is a multiple of 8.
package bsr_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } bsr_op_e;

    localparam int LANE_W   = 8;
    localparam int POLL_BIT = 7;
    localparam int TGL_BIT  = 6;

    // Build the mask of every status bit position for a given width.
    function automatic logic [63:0] status_mask(input int width);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < width / LANE_W; i++) begin
            m[i * LANE_W + POLL_BIT] = 1'b1;
            m[i * LANE_W + TGL_BIT]  = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/bsr_op_timer.sv
// Operation timer.
// Accepts a start only while idle. It loads the duration for the requested
// operation kind and holds busy for exactly that many cycles. It then drops
// busy and pulses done for one cycle. Assumes both durations are at least 1.
module bsr_op_timer
    import bsr_pkg::*;
#(
    parameter int unsigned PROG_CYCLES  = 2500,
    parameter int unsigned ERASE_CYCLES = 5000000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  bsr_op_e op_i,
    output logic    accept_o,
    output logic    busy_o,
    output logic    done_o
);

    localparam int unsigned MAX_CYCLES = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int          CNT_W      = (MAX_CYCLES > 1) ? $clog2(MAX_CYCLES) : 1;
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;

    // A start is taken only when no operation is running.
    assign accept_o = start_i && !busy_q;

    // Load, count down and retire the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                cnt_q  <= (op_i == OP_ERASE) ? ERASE_LOAD : PROG_LOAD;
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

endmodule

// File: rtl/bsr_capture.sv
// Operation capture register.
// Holds the operation kind and the last loaded word from the accepted start
// until the next accepted start. Strobes that the timer refuses never reach it.
module bsr_capture
    import bsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  bsr_op_e           op_i,
    input  logic [DATA_W-1:0] data_i,
    output bsr_op_e           op_o,
    output logic [DATA_W-1:0] data_o
);

    bsr_op_e           op_q;
    logic [DATA_W-1:0] data_q;

    // Latch kind and word on an accepted start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_PROG;
            data_q <= '0;
        end else if (accept_i) begin
            op_q   <= op_i;
            data_q <= data_i;
        end
    end

    assign op_o   = op_q;
    assign data_o = data_q;

endmodule

// File: rtl/bsr_toggle.sv
// Toggle bit generator.
// Starts at 0 with each accepted operation. It inverts once for each
// read strobe seen while the operation is busy.
module bsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic busy_i,
    input  logic rd_i,
    output logic tgl_o
);

    logic tgl_q;

    // Clear on a new operation, flip on each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else if (accept_i) begin
            tgl_q <= 1'b0;
        end else if (busy_i && rd_i) begin
            tgl_q <= ~tgl_q;
        end
    end

    assign tgl_o = tgl_q;

endmodule

// File: rtl/bsr_status_mux.sv
// Read data status overlay.
// For each byte lane, while busy, replaces the polling bit and the toggle bit
// and passes the rest of the array data. When idle it passes the whole word.
// Purely combinational. Assumes DATA_W is a multiple of 8.
module bsr_status_mux
    import bsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              busy_i,
    input  bsr_op_e           op_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              tgl_i,
    input  logic [DATA_W-1:0] array_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane;

        // Overlay the status bits of this lane while busy.
        always_comb begin
            lane = array_i[g*LANE_W +: LANE_W];
            if (busy_i) begin
                lane[POLL_BIT] = (op_i == OP_ERASE) ? 1'b0 : ~wdata_i[g*LANE_W + POLL_BIT];
                lane[TGL_BIT]  = tgl_i;
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = lane;
    end

endmodule

// File: rtl/busy_status_reporter.sv
// Program/erase busy status reporter, top level.
// Times a self-running program or erase started by a one-cycle strobe.
// While busy, it overlays polling and toggle status on host reads. It
// then pulses done for one cycle and returns to plain reads. Assumes the
// command decoder gives only a single-cycle start and that the array
// itself performs the commit on done.
module busy_status_reporter
    import bsr_pkg::*;
#(
    parameter int          DATA_W       = 16,
    parameter int unsigned PROG_CYCLES  = 2500,
    parameter int unsigned ERASE_CYCLES = 5000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              done_o
);

    bsr_op_e           req_op;
    bsr_op_e           lat_op;
    logic [DATA_W-1:0] lat_data;
    logic              accept;
    logic              busy;
    logic              tgl;

    assign req_op = bsr_op_e'(op_erase_i);

    bsr_op_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (req_op),
        .accept_o(accept),
        .busy_o  (busy),
        .done_o  (done_o)
    );

    bsr_capture #(
        .DATA_W(DATA_W)
    ) capture_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept_i(accept),
        .op_i    (req_op),
        .data_i  (wdata_i),
        .op_o    (lat_op),
        .data_o  (lat_data)
    );

    bsr_toggle toggle_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept_i(accept),
        .busy_i  (busy),
        .rd_i    (rd_i),
        .tgl_o   (tgl)
    );

    bsr_status_mux #(
        .DATA_W(DATA_W)
    ) mux_i (
        .busy_i (busy),
        .op_i   (lat_op),
        .wdata_i(lat_data),
        .tgl_i  (tgl),
        .array_i(array_data_i),
        .rdata_o(rd_data_o)
    );

    assign busy_o = busy;

endmodule

// File: rtl/busy_status_reporter_chk.sv
// Assertion checker for the busy status reporter, bound to the top level.
// Relates the timer outputs, the captured operation and the read data.
module busy_status_reporter_chk
    import bsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_i,
    input logic [DATA_W-1:0] array_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              busy_o,
    input logic              done_o,
    input bsr_op_e           lat_op,
    input logic [DATA_W-1:0] lat_data
);

    localparam logic [DATA_W-1:0] STAT_MASK = status_mask(DATA_W)[DATA_W-1:0];

    // R2
    start_idle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R3
    busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R4
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (lat_data == $past(lat_data) && lat_op == $past(lat_op)));

    // R5
    prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && lat_op == OP_PROG) |-> (rd_data_o[7] == !lat_data[7] && rd_data_o[15] == !lat_data[15]));

    // R6
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && lat_op == OP_ERASE) |-> (!rd_data_o[7] && !rd_data_o[15]));

    // R7
    toggle_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rd_data_o[14] == rd_data_o[6]));

    // R7
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rd_i) |=> (!busy_o || rd_data_o[6] == $past(rd_data_o[6])));

    // R8
    busy_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ((rd_data_o & ~STAT_MASK) == (array_data_i & ~STAT_MASK)));

    // R9
    idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (rd_data_o == array_data_i));

endmodule

bind busy_status_reporter busy_status_reporter_chk #(
    .DATA_W(DATA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rd_i        (rd_i),
    .array_data_i(array_data_i),
    .rd_data_o   (rd_data_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .lat_op      (lat_op),
    .lat_data    (lat_data)
);

// File: tb/busy_status_reporter_tb_top.sv
// Bench for the busy status reporter: sweeps loaded-word patterns and read
// patterns over short operation lengths and models the expected read data.
module busy_status_reporter_tb_top;

    localparam int DW    = 16;
    localparam int PROG  = 5;
    localparam int ERASE = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_erase_i = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic          rd_i = 1'b0;
    logic [DW-1:0] array_data_i = '0;
    logic [DW-1:0] rd_data_o;
    logic          busy_o;
    logic          done_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    busy_status_reporter #(
        .DATA_W      (DW),
        .PROG_CYCLES (PROG),
        .ERASE_CYCLES(ERASE)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .op_erase_i  (op_erase_i),
        .wdata_i     (wdata_i),
        .rd_i        (rd_i),
        .array_data_i(array_data_i),
        .rd_data_o   (rd_data_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Runs one operation; poke injects a conflicting start on busy cycle 2.
    task automatic run_op(input logic is_erase, input logic [DW-1:0] wd,
                          input logic [7:0] rd_mask, input bit poke);
        int            n_exp;
        int            nb;
        logic          tgl;
        logic [DW-1:0] arr;
        logic [DW-1:0] exp;
        n_exp = is_erase ? ERASE : PROG;
        nb    = 0;
        tgl   = 1'b0;
        @(negedge clk);
        start_i = 1'b1; op_erase_i = is_erase; wdata_i = wd; rd_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; wdata_i = '0;
        while (busy_o && nb < 100) begin
            nb++;
            if (poke && nb == 2) begin
                start_i = 1'b1; op_erase_i = ~is_erase; wdata_i = ~wd;
            end else begin
                start_i = 1'b0;
            end
            arr  = 16'hA5C3 ^ DW'(nb * 16'h1357) ^ wd;
            array_data_i = arr;
            rd_i = rd_mask[nb % 8];
            #1;
            exp = arr;
            exp[7]  = is_erase ? 1'b0 : ~wd[7];
            exp[15] = is_erase ? 1'b0 : ~wd[15];
            exp[6]  = tgl;
            exp[14] = tgl;
            chk(is_erase ? "R6 R7 R8 erase busy read" : "R5 R7 R8 program busy read",
                32'(rd_data_o), 32'(exp));
            if (rd_i) tgl = ~tgl;
            @(negedge clk);
        end
        start_i = 1'b0; rd_i = 1'b1; wdata_i = '0;
        array_data_i = is_erase ? 16'hFFFF : wd;
        #1;
        chk(poke ? "R4 busy length with ignored start" : "R2 busy length", 32'(nb), 32'(n_exp));
        chk("R3 done pulse after busy", 32'(done_o), 32'd1);
        chk("R10 R9 read after completion", 32'(rd_data_o), 32'(array_data_i));
        @(negedge clk);
        array_data_i = 16'h3C5A ^ wd;
        #1;
        chk("R3 done lasts one cycle", 32'(done_o), 32'd0);
        chk("R9 idle read passes array", 32'(rd_data_o), 32'(array_data_i));
        @(negedge clk);
        #1;
        chk("R9 idle read starts nothing", 32'(busy_o), 32'd0);
        rd_i = 1'b0;
    endtask

    initial begin
        array_data_i = 16'h1234;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 busy after reset", 32'(busy_o), 32'd0);
        chk("R1 done after reset", 32'(done_o), 32'd0);
        chk("R1 read after reset", 32'(rd_data_o), 32'(array_data_i));
        for (int v = 0; v < 16; v++) begin
            logic [DW-1:0] wd;
            wd = 16'h2B1D ^ DW'(v * 16'h0101);
            wd[15] = v[3]; wd[14] = v[2]; wd[7] = v[1]; wd[6] = v[0];
            run_op(1'b0, wd, 8'(v * 7 + 1), (v % 4) == 1);
        end
        for (int e = 0; e < 4; e++) begin
            run_op(1'b1, 16'(e * 16'h4E21), 8'(e * 37 + 3), e[0]);
        end
        run_op(1'b0, 16'h8080, 8'hFF, 1'b1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule